// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside an 8-bit microcontroller core. It collects seven interrupt requests and picks one to present to the CPU. The seven requests come from two external pins, three timers, a serial port and an I2C interface. Two 8-bit configuration registers control the choice: one holds the enable mask and one holds the level selection. Both are written and read through a small register port.

A pending, enabled request belongs to either the high or the low level. A high-level request always wins over a low-level one. Inside one level, a fixed polling order decides. The controller registers the winner and presents it as a request line, a level flag and a 16-bit vector address. The CPU takes the request with a one-cycle acknowledge. The controller then marks that level as in service. A return pulse ends the most recent service. A low-level service can be interrupted by a high-level request. A service at the same level cannot be interrupted, and nothing interrupts a high-level service. Clearing the source flags is left to the sources and to software.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and both configuration registers read 0.
- R2: With `cfg_sel`=0 the enable register is written and read. With `cfg_sel`=1 the level register is written and read. Bit 7 of the level register always reads 0, and the write takes effect at the clock edge where `cfg_wr`=1.
- R3: When enable bit 7 (global enable) is 0, no request is presented, whatever the sources and the other bits.
- R4: Enable bits mask single sources at these positions: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2, bit 6 I2C. The same positions in the level register select high level (1) or low level (0).
- R5: The presented vector is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, 0x0023 for serial, 0x002B for timer 2 and 0x0053 for I2C.
- R6: Within one level, the winner follows this order, first to last: external 0, timer 2, I2C, timer 0, external 1, timer 1, serial.
- R7: Any pending high-level source beats every pending low-level source, whatever the polling order. `irq_hi` gives the level of the presented request.
- R8: The timer 2 request is the OR of its overflow and external inputs. The serial request is the OR of its receive and transmit inputs.
- R9: The request, vector and level are registered. They reflect the sources and registers as they were one clock earlier. After an edge where `irq_ack`=1 and `irq_req`=1, `irq_req` is 0 for one cycle.
- R10: During a low-level service, only high-level requests are presented. During a high-level service, no request is presented.
- R11: A return pulse ends the high-level service if one is active, and otherwise the low-level one. After the return, requests that were held back are presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 level |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| ext0_irq | input | 1 | External 0 request |
| tmr0_irq | input | 1 | Timer 0 request |
| ext1_irq | input | 1 | External 1 request |
| tmr1_irq | input | 1 | Timer 1 request |
| ser_rx_irq | input | 1 | Serial receive request |
| ser_tx_irq | input | 1 | Serial transmit request |
| tmr2_ovf_irq | input | 1 | Timer 2 overflow request |
| tmr2_ext_irq | input | 1 | Timer 2 external request |
| i2c_irq | input | 1 | I2C request |
| irq_req | output | 1 | Request to the CPU |
| irq_hi | output | 1 | Level of the presented request, 1 = high |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | Return-from-interrupt pulse |

## Verification
The register read port is combinational, so read data is checked in the same cycle the select is driven. The request, level and vector are due at the first clock edge after sources, register writes, acknowledges or returns change. The bench drives every input on the falling edge. It computes the expected output from its own model of the registers and in-service state as they stood before the next rising edge. It then compares at the following falling edge, after exactly one register stage. An acknowledge is judged against the request the model expects in that same cycle. So the forced one-cycle drop and the later in-service blocking are each checked at the edge where they take effect.

// File: rtl/irqc_pkg.sv
// Package: shared constants, source indices and lookup functions for the
// interrupt controller. Assumes seven sources and an 8-bit register port.
package irqc_pkg;
    localparam int NUM_SRC = 7;
    localparam int REG_W   = 8;
    localparam int VEC_W   = 16;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int GEN_BIT = REG_W - 1;

    // Source index equals its bit position in both configuration registers.
    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_I2C  = 3'd6
    } src_e;

    // Source polled at a given position inside one level (0 = first).
    function automatic logic [IDX_W-1:0] poll_src(input int pos);
        case (pos)
            0:       return SRC_EXT0;
            1:       return SRC_TMR2;
            2:       return SRC_I2C;
            3:       return SRC_TMR0;
            4:       return SRC_EXT1;
            5:       return SRC_TMR1;
            default: return SRC_SER;
        endcase
    endfunction

    // Vector address of a source: eight-byte spacing, I2C placed apart.
    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        if (idx == SRC_I2C)
            return VEC_W'(16'h0053);
        return VEC_W'(16'h0003) + VEC_W'({idx, 3'b000});
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
// Module: enable and level registers behind a simple write/read port.
// Assumes: one write per cycle, select 0 = enable, 1 = level; the top bit
// of the level register is not stored and reads as zero.
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] pr_q,
    output logic [DW-1:0] rdata
);
    localparam int PR_BITS = DW - 1;

    logic [PR_BITS-1:0] pr_store;

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            pr_store <= '0;
        end else if (wr) begin
            if (sel) pr_store <= wdata[PR_BITS-1:0];
            else     en_q     <= wdata;
        end
    end

    // Present the level register with its top bit forced to zero.
    always_comb pr_q = {1'b0, pr_store};

    // Select the read data.
    always_comb rdata = sel ? pr_q : en_q;
endmodule

// File: rtl/irqc_arbiter.sv
// Module: picks the winning source among masked pending requests.
// Assumes: pend is already gated by enables; high level beats low level,
// the package polling order breaks ties; in-service flags block levels.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int IW   = IDX_W
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] lvl_hi,
    input  logic            hi_busy,
    input  logic            lo_busy,
    output logic            win_valid,
    output logic            win_hi,
    output logic [IW-1:0]   win_idx
);
    logic [NSRC-1:0] hi_hit;
    logic [NSRC-1:0] lo_hit;

    // Reorder requests into polling positions, split by level.
    for (genvar p = 0; p < NSRC; p++) begin : g_poll
        localparam logic [IW-1:0] SRC = IW'(poll_src(p));
        assign hi_hit[p] = pend[SRC] &  lvl_hi[SRC];
        assign lo_hit[p] = pend[SRC] & ~lvl_hi[SRC];
    end

    // Scan last-to-first so the earliest hit wins; high level overrides.
    always_comb begin
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (!hi_busy && !lo_busy) begin
            for (int p = NSRC - 1; p >= 0; p--) begin
                if (lo_hit[p]) begin
                    win_valid = 1'b1;
                    win_hi    = 1'b0;
                    win_idx   = IW'(poll_src(p));
                end
            end
        end
        if (!hi_busy) begin
            for (int p = NSRC - 1; p >= 0; p--) begin
                if (hi_hit[p]) begin
                    win_valid = 1'b1;
                    win_hi    = 1'b1;
                    win_idx   = IW'(poll_src(p));
                end
            end
        end
    end
endmodule

// File: rtl/irqc_level_track.sv
// Module: per-level in-service flags.
// Assumes: an accepted acknowledge marks its level; a return clears the
// high level first, else the low level; acknowledge wins if both coincide.
module irqc_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_fire,
    input  logic ack_hi,
    input  logic ret,
    output logic hi_busy,
    output logic lo_busy
);
    // Update the in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_busy <= 1'b0;
            lo_busy <= 1'b0;
        end else if (ack_fire) begin
            if (ack_hi) hi_busy <= 1'b1;
            else        lo_busy <= 1'b1;
        end else if (ret) begin
            if (hi_busy) hi_busy <= 1'b0;
            else         lo_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the two-level interrupt controller.
// Assumes: source inputs are level requests synchronous to clk; the CPU
// acknowledges only while irq_req is high and pulses irq_ret once per end
// of service. Outputs are registered one stage after the arbitration.
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             ext0_irq,
    input  logic             tmr0_irq,
    input  logic             ext1_irq,
    input  logic             tmr1_irq,
    input  logic             ser_rx_irq,
    input  logic             ser_tx_irq,
    input  logic             tmr2_ovf_irq,
    input  logic             tmr2_ext_irq,
    input  logic             i2c_irq,
    output logic             irq_req,
    output logic             irq_hi,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    logic [REG_W-1:0]   en_q;
    logic [REG_W-1:0]   pr_q;
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] pend;
    logic               hi_busy;
    logic               lo_busy;
    logic               win_valid;
    logic               win_hi;
    logic [IDX_W-1:0]   win_idx;
    logic               ack_fire;

    irqc_cfg_regs #(.DW(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .en_q  (en_q),
        .pr_q  (pr_q),
        .rdata (cfg_rdata)
    );

    // Gather source requests by register bit position, merging paired flags.
    always_comb begin
        raw           = '0;
        raw[SRC_EXT0] = ext0_irq;
        raw[SRC_TMR0] = tmr0_irq;
        raw[SRC_EXT1] = ext1_irq;
        raw[SRC_TMR1] = tmr1_irq;
        raw[SRC_SER]  = ser_rx_irq | ser_tx_irq;
        raw[SRC_TMR2] = tmr2_ovf_irq | tmr2_ext_irq;
        raw[SRC_I2C]  = i2c_irq;
    end

    // Apply the individual and global enables.
    always_comb pend = raw & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[GEN_BIT]}};

    irqc_arbiter #(.NSRC(NUM_SRC), .IW(IDX_W)) u_arb (
        .pend      (pend),
        .lvl_hi    (pr_q[NUM_SRC-1:0]),
        .hi_busy   (hi_busy),
        .lo_busy   (lo_busy),
        .win_valid (win_valid),
        .win_hi    (win_hi),
        .win_idx   (win_idx)
    );

    // An acknowledge counts only against a presented request.
    always_comb ack_fire = irq_ack & irq_req;

    irqc_level_track u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_fire (ack_fire),
        .ack_hi   (irq_hi),
        .ret      (irq_ret),
        .hi_busy  (hi_busy),
        .lo_busy  (lo_busy)
    );

    // Register the winner; withdraw the request for the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_hi  <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_req <= win_valid & ~ack_fire;
            irq_hi  <= win_hi;
            irq_vec <= vector_of(win_idx);
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: property checks for the interrupt controller, bound to its top.
module irqc_checker
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_hi,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic             irq_ret,
    input logic [REG_W-1:0] en_q,
    input logic             hi_busy,
    input logic             lo_busy,
    input logic             cfg_sel,
    input logic [REG_W-1:0] cfg_rdata
);
    assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(en_q[GEN_BIT]));

    assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    assert_hi_blocks_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(hi_busy));

    assert_lo_only_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(lo_busy)) |-> irq_hi);

    assert_ret_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && hi_busy) |=> (!hi_busy && lo_busy == $past(lo_busy)));

    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B || irq_vec == 16'h0013 ||
                     irq_vec == 16'h001B || irq_vec == 16'h0023 || irq_vec == 16'h002B ||
                     irq_vec == 16'h0053));

    assert_lvl_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> !cfg_rdata[GEN_BIT]);
endmodule

bind prio_irq_ctrl irqc_checker u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_hi    (irq_hi),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .en_q      (en_q),
    .hi_busy   (hi_busy),
    .lo_busy   (lo_busy),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0, cfg_rdata;
    logic [8:0]  src = '0;
    logic        irq_req, irq_hi, irq_ack = 1'b0, irq_ret = 1'b0;
    logic [15:0] irq_vec;
    int          total = 0, bad = 0;
    logic [7:0]  m_en = '0, m_pr = '0;
    logic        m_hb = 1'b0, m_lb = 1'b0, m_req = 1'b0, m_hi = 1'b0;
    logic [15:0] m_vec = '0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ext0_irq(src[0]), .tmr0_irq(src[1]), .ext1_irq(src[2]), .tmr1_irq(src[3]),
        .ser_rx_irq(src[4]), .ser_tx_irq(src[5]), .tmr2_ovf_irq(src[6]),
        .tmr2_ext_irq(src[7]), .i2c_irq(src[8]),
        .irq_req(irq_req), .irq_hi(irq_hi), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected vectors per register bit position (R5).
    function automatic logic [15:0] exp_vec(input int i);
        case (i)
            0: return 16'h0003; 1: return 16'h000B; 2: return 16'h0013;
            3: return 16'h001B; 4: return 16'h0023; 5: return 16'h002B;
            default: return 16'h0053;
        endcase
    endfunction

    // Model of winner selection from the requirements: {valid, hi, vec}.
    function automatic logic [17:0] model(input logic [8:0] s, input logic [7:0] en,
                                          input logic [7:0] pr, input logic hb, input logic lb);
        int ord[7] = '{0, 5, 6, 1, 2, 3, 4};
        logic [6:0] raw, pend;
        raw  = {s[8], s[6] | s[7], s[4] | s[5], s[3], s[2], s[1], s[0]};
        pend = en[7] ? (raw & en[6:0]) : 7'd0;
        if (hb) return '0;
        for (int k = 0; k < 7; k++)
            if (pend[ord[k]] && pr[ord[k]]) return {1'b1, 1'b1, exp_vec(ord[k])};
        if (lb) return '0;
        for (int k = 0; k < 7; k++)
            if (pend[ord[k]] && !pr[ord[k]]) return {1'b1, 1'b0, exp_vec(ord[k])};
        return '0;
    endfunction

    // One cycle: drive at the falling edge, predict, compare one edge later.
    task automatic step(input logic [8:0] s, input logic wr, input logic sel,
                        input logic [7:0] wd, input logic ack, input logic ret, input string tag);
        logic [17:0] nx;
        logic        fire;
        src = s; cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd; irq_ack = ack; irq_ret = ret;
        fire = ack & m_req;
        nx   = model(s, m_en, m_pr, m_hb, m_lb);
        if (fire) begin
            if (m_hi) m_hb = 1'b1; else m_lb = 1'b1;
        end else if (ret) begin
            if (m_hb) m_hb = 1'b0; else m_lb = 1'b0;
        end
        if (wr) begin
            if (sel) m_pr = wd & 8'h7F; else m_en = wd;
        end
        m_req = nx[17] & ~fire; m_hi = nx[16]; m_vec = nx[15:0];
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
        check({tag, " req"}, irq_req, m_req);
        if (m_req) begin
            check({tag, " vec"}, irq_vec, m_vec);
            check({tag, " lvl"}, irq_hi, m_hi);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d, input string tag);
        step(9'd0, 1'b1, sel, d, 1'b0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int dummy;
        logic [8:0] s;
        dummy = $urandom(32'd8051);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req", irq_req, 0);
        cfg_sel = 1'b0; #1 check("R1 en", cfg_rdata, 0);
        cfg_sel = 1'b1; #1 check("R1 pr", cfg_rdata, 0);
        @(negedge clk);
        // R2 register access
        wr_reg(1'b0, 8'hA5, "R2 wr en");
        cfg_sel = 1'b0; #1 check("R2 en readback", cfg_rdata, 8'hA5);
        @(negedge clk);
        wr_reg(1'b1, 8'hFF, "R2 wr pr");
        cfg_sel = 1'b1; #1 check("R2 pr top bit zero", cfg_rdata, 8'h7F);
        @(negedge clk);
        wr_reg(1'b1, 8'h00, "R2 pr clr");
        // R3 global enable off
        wr_reg(1'b0, 8'h7F, "R3 en");
        step(9'h1FF, 0, 0, 0, 0, 0, "R3 all pending");
        step(9'h1FF, 0, 0, 0, 0, 0, "R3 all pending");
        // R5 each source alone, R9 one-clock latency
        wr_reg(1'b0, 8'hFF, "R5 en");
        for (int i = 0; i < 9; i++) begin
            step(9'(1 << i), 0, 0, 0, 0, 0, "R5 R8 R9 single");
            step(9'd0, 0, 0, 0, 0, 0, "R9 drop");
        end
        // R4 individual masks
        for (int b = 0; b < 7; b++) begin
            wr_reg(1'b0, 8'h80 | (8'h7F & ~(8'(1) << b)), "R4 mask");
            step(9'h1FF, 0, 0, 0, 0, 0, "R4 masked others win");
        end
        wr_reg(1'b0, 8'h81, "R4 only ext0");
        step(9'h1FE, 0, 0, 0, 0, 0, "R4 ext0 masked off");
        wr_reg(1'b0, 8'hFF, "R6 en");
        // R6 polling order: peel winners off one by one
        s = 9'h1FF;
        step(s, 0, 0, 0, 0, 0, "R6 order ext0");
        s[0] = 0;          step(s, 0, 0, 0, 0, 0, "R6 order tmr2");
        s[7:6] = 0;        step(s, 0, 0, 0, 0, 0, "R6 order i2c");
        s[8] = 0;          step(s, 0, 0, 0, 0, 0, "R6 order tmr0");
        s[1] = 0;          step(s, 0, 0, 0, 0, 0, "R6 order ext1");
        s[2] = 0;          step(s, 0, 0, 0, 0, 0, "R6 order tmr1");
        s[3] = 0;          step(s, 0, 0, 0, 0, 0, "R6 order serial");
        // R7 high level beats polling order
        wr_reg(1'b1, 8'h10, "R7 serial high");
        step(9'h1FF, 0, 0, 0, 0, 0, "R7 serial high wins");
        wr_reg(1'b1, 8'h0A, "R7 tmr0 tmr1 high");
        step(9'h1FF, 0, 0, 0, 0, 0, "R7 tmr0 high wins");
        // R8 paired inputs
        wr_reg(1'b1, 8'h00, "R8 pr");
        step(9'h040, 0, 0, 0, 0, 0, "R8 tmr2 ovf");
        step(9'h080, 0, 0, 0, 0, 0, "R8 tmr2 ext");
        step(9'h010, 0, 0, 0, 0, 0, "R8 ser rx");
        step(9'h020, 0, 0, 0, 0, 0, "R8 ser tx");
        // R10 / R11 nesting: ext0 high, others low
        wr_reg(1'b1, 8'h01, "R10 pr");
        step(9'h008, 0, 0, 0, 0, 0, "R10 tmr1 low req");
        step(9'h008, 0, 0, 0, 1, 0, "R9 ack drop");
        step(9'h00C, 0, 0, 0, 0, 0, "R10 low blocks low");
        step(9'h00D, 0, 0, 0, 0, 0, "R10 high preempts");
        step(9'h00D, 0, 0, 0, 1, 0, "R10 ack high");
        step(9'h00D, 0, 0, 0, 0, 0, "R10 high blocks all");
        step(9'h00D, 0, 0, 0, 0, 0, "R10 high blocks all");
        step(9'h00D, 0, 0, 0, 0, 1, "R11 ret high");
        step(9'h00C, 0, 0, 0, 0, 0, "R11 low still busy");
        step(9'h00C, 0, 0, 0, 0, 1, "R11 ret low");
        step(9'h00C, 0, 0, 0, 0, 0, "R11 low resumes");
        step(9'h000, 0, 0, 0, 0, 1, "R11 idle ret");
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [8:0] rs;
            logic       wr, sel, ack, ret;
            logic [7:0] wd;
            rs  = 9'($urandom & $urandom);
            wr  = ($urandom % 10) == 0;
            sel = $urandom % 2;
            wd  = 8'($urandom);
            if (!sel && ($urandom % 8) != 0) wd[7] = 1'b1;
            ack = m_req && ($urandom % 2);
            ret = !ack && (($urandom % 6) == 0);
            step(rs, wr, sel, wd, ack, ret, "R4 R6 R7 R9 R10 R11 random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule